// File: doc/BRIEF.md
# Dual-Channel Angle Readout Latch

This block sits between two continuously tracking angle converters and a shared 14-bit parallel read port. Each converter delivers a new angle word together with a one-cycle update strobe whenever its count moves. The block keeps one output latch per channel and places the chosen latch on a common data bus. The bus has an active-low enable. A per-bit drive-enable output stands in for pad-level three-state control.

While a channel is enabled and selected, its output latch is frozen, so the reader sees a word that cannot change under it. A separate tracking register behind each latch keeps taking every update, so no converter motion is lost. The first clock after the read ends reloads the latch with the newest tracked angle.

A data-valid flag stays low for a fixed settling interval, given as a parameter in clock cycles, after the enable falls or the select changes level. This models the access time of the port.

Top module: `angle_readout_mux`

## Requirements
- R1: While `oe_ni` is low, `data_o` shows channel A's latch when `sel_a_i` is 1 and channel B's latch when `sel_a_i` is 0. The word is natural binary: `data_o[13]` is the most significant bit (half a turn) and `data_o[0]` the least (1/16384 turn).
- R2: While `oe_ni` is high, `drive_en_o` is all zeros and `data_o` is zero. While `oe_ni` is low, `drive_en_o` is all ones.
- R3: A channel whose latch is read (`oe_ni` low at the clock edge and the channel selected) ignores its update strobe at that edge, so `data_o` stays stable while the same channel is read.
- R4: A channel that is not being read loads its input angle into its latch at every clock edge where its update strobe is high.
- R5: Updates that arrive while a latch is frozen are kept in a tracking register. At the first clock edge after the read ends, the latch loads the newest of them.
- R6: After `oe_ni` is first sampled low at a clock edge, `valid_o` stays low through the next SETTLE_CYC-1 edges and rises after the SETTLE_CYC-th edge, counting that first edge as number 1 (default 32 cycles, 640 ns at 50 MHz).
- R7: A level change of `sel_a_i` drops `valid_o` at once, in the same cycle, and restarts the settling count in the same way as R6.
- R8: `valid_o` is low whenever `oe_ni` is high. After reset, the bus is released, both latches hold zero and the settling count is restarted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ang_a_i | input | 14 | Channel A tracked angle |
| upd_a_i | input | 1 | Channel A update strobe |
| ang_b_i | input | 14 | Channel B tracked angle |
| upd_b_i | input | 1 | Channel B update strobe |
| oe_ni | input | 1 | Output enable, active low |
| sel_a_i | input | 1 | Channel select, 1 = A, 0 = B |
| data_o | output | 14 | Selected angle word, zero when released |
| drive_en_o | output | 14 | Per-bit bus drive enable |
| valid_o | output | 1 | Data settled and valid |

## Verification
An update strobe and the start of a read can fall on the same clock edge. In that case the freeze has to win over the load into the latch, while the tracking register still takes the new angle. The vector table provokes this by lowering the enable in the same cycle that both channels strobe. It then judges the result over the following cycles: the read channel must still show its old word, the other channel must show its new one, and after the read ends the first channel must show its newest tracked angle. A second collision is a select change while the settling count runs down. The bench checks that the flag drops in that same cycle and needs a full new interval to rise again.

// File: rtl/angle_readout_pkg.sv
package angle_readout_pkg;
  localparam int unsigned DEF_ANGLE_W   = 14;
  localparam int unsigned DEF_SETTLE_CYC = 32;
  localparam int unsigned NUM_CH        = 2;

  typedef enum logic {
    CH_B = 1'b0,
    CH_A = 1'b1
  } chan_e;
endpackage

// File: rtl/angle_chan_latch.sv
module angle_chan_latch #(
  parameter int unsigned ANGLE_W = 14
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ANGLE_W-1:0] ang_i,
  input  logic               upd_i,
  input  logic               freeze_i,
  output logic [ANGLE_W-1:0] hold_o
);
  logic [ANGLE_W-1:0] trk_q;
  logic [ANGLE_W-1:0] trk_d;

  // newest tracked angle, including one arriving this cycle
  assign trk_d = upd_i ? ang_i : trk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trk_q  <= '0;
      hold_o <= '0;
    end else begin
      trk_q <= trk_d;
      if (!freeze_i) hold_o <= trk_d;
    end
  end
endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
  parameter int unsigned SETTLE_CYC = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic oe_ni,
  input  logic sel_i,
  output logic valid_o
);
  localparam int unsigned CNT_W = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(SETTLE_CYC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             sel_q;
  logic             oe_nq;
  logic             restart;

  assign restart = (sel_i != sel_q) || (oe_nq && !oe_ni);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= LOAD;
      sel_q <= 1'b0;
      oe_nq <= 1'b1;
    end else begin
      sel_q <= sel_i;
      oe_nq <= oe_ni;
      if (restart)           cnt_q <= LOAD;
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end
  end

  assign valid_o = !oe_ni && !restart && (cnt_q == '0);
endmodule

// File: rtl/angle_bus_drive.sv
module angle_bus_drive
  import angle_readout_pkg::*;
#(
  parameter int unsigned ANGLE_W = 14
) (
  input  logic [ANGLE_W-1:0] hold_a_i,
  input  logic [ANGLE_W-1:0] hold_b_i,
  input  logic               sel_a_i,
  input  logic               oe_ni,
  output logic [ANGLE_W-1:0] data_o,
  output logic [ANGLE_W-1:0] drive_en_o
);
  chan_e ch;
  assign ch = chan_e'(sel_a_i);

  always_comb begin
    data_o     = '0;
    drive_en_o = '0;
    if (!oe_ni) begin
      drive_en_o = '1;
      data_o     = (ch == CH_A) ? hold_a_i : hold_b_i;
    end
  end
endmodule

// File: rtl/angle_readout_mux.sv
module angle_readout_mux
  import angle_readout_pkg::*;
#(
  parameter int unsigned ANGLE_W    = DEF_ANGLE_W,
  parameter int unsigned SETTLE_CYC = DEF_SETTLE_CYC
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ANGLE_W-1:0] ang_a_i,
  input  logic               upd_a_i,
  input  logic [ANGLE_W-1:0] ang_b_i,
  input  logic               upd_b_i,
  input  logic               oe_ni,
  input  logic               sel_a_i,
  output logic [ANGLE_W-1:0] data_o,
  output logic [ANGLE_W-1:0] drive_en_o,
  output logic               valid_o
);
  logic [ANGLE_W-1:0] ang_in  [NUM_CH];
  logic [ANGLE_W-1:0] hold    [NUM_CH];
  logic [NUM_CH-1:0]  upd_in;

  assign ang_in[CH_B] = ang_b_i;
  assign ang_in[CH_A] = ang_a_i;
  assign upd_in       = {upd_a_i, upd_b_i};

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic frz;
    assign frz = !oe_ni && (sel_a_i == 1'(c));

    angle_chan_latch #(.ANGLE_W(ANGLE_W)) u_latch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .ang_i    (ang_in[c]),
      .upd_i    (upd_in[c]),
      .freeze_i (frz),
      .hold_o   (hold[c])
    );
  end

  angle_bus_drive #(.ANGLE_W(ANGLE_W)) u_drive (
    .hold_a_i   (hold[CH_A]),
    .hold_b_i   (hold[CH_B]),
    .sel_a_i    (sel_a_i),
    .oe_ni      (oe_ni),
    .data_o     (data_o),
    .drive_en_o (drive_en_o)
  );

  settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .oe_ni   (oe_ni),
    .sel_i   (sel_a_i),
    .valid_o (valid_o)
  );
endmodule

// File: rtl/angle_readout_mux_chk.sv
module angle_readout_mux_chk #(
  parameter int unsigned ANGLE_W = 14
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               oe_ni,
  input logic               sel_a_i,
  input logic [ANGLE_W-1:0] data_o,
  input logic [ANGLE_W-1:0] drive_en_o,
  input logic               valid_o
);
  // R2
  bus_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> (drive_en_o == '0 && data_o == '0));

  // R2
  drive_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_ni |-> (drive_en_o == '1));

  // R3
  frozen_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!oe_ni && $past(!oe_ni) && (sel_a_i == $past(sel_a_i))) |-> $stable(data_o));

  // R8
  valid_needs_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !oe_ni);

  // R7
  sel_change_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_a_i != $past(sel_a_i)) |-> !valid_o);

  // R6
  valid_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> $past(!oe_ni));
endmodule

bind angle_readout_mux angle_readout_mux_chk #(.ANGLE_W(ANGLE_W)) u_chk (.*);

// File: tb/angle_readout_mux_test.sv
module angle_readout_mux_test;
  localparam int W = 14;
  localparam int SETTLE = 32;

  typedef struct packed {
    logic         oe_n;
    logic         sel;
    logic [W-1:0] a;
    logic         ua;
    logic [W-1:0] b;
    logic         ub;
    logic         exp_on;
    logic [W-1:0] exp_data;
  } vec_t;

  // one vector per clock; expected values seen after that edge
  localparam vec_t VECS [8] = '{
    '{1'b1, 1'b1, 14'h1234, 1'b1, 14'h0abc, 1'b1, 1'b0, 14'h0000}, // R2 R4 idle loads
    '{1'b0, 1'b1, 14'h1111, 1'b1, 14'h2222, 1'b1, 1'b1, 14'h1234}, // R3 freeze beats strobe
    '{1'b0, 1'b1, 14'h1555, 1'b1, 14'h0333, 1'b1, 1'b1, 14'h1234}, // R3 still frozen
    '{1'b0, 1'b0, 14'h0777, 1'b0, 14'h3000, 1'b0, 1'b1, 14'h0333}, // R1 R4 B read
    '{1'b0, 1'b1, 14'h0000, 1'b0, 14'h3fff, 1'b1, 1'b1, 14'h1555}, // R5 A reload
    '{1'b1, 1'b1, 14'h0001, 1'b1, 14'h0000, 1'b0, 1'b0, 14'h0000}, // R2 released
    '{1'b0, 1'b0, 14'h0000, 1'b0, 14'h0000, 1'b0, 1'b1, 14'h3fff}, // R1 MSB..LSB all set
    '{1'b0, 1'b1, 14'h0000, 1'b0, 14'h0000, 1'b0, 1'b1, 14'h0001}  // R1 LSB only
  };

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] ang_a_i = '0, ang_b_i = '0;
  logic         upd_a_i = 1'b0, upd_b_i = 1'b0;
  logic         oe_ni = 1'b1, sel_a_i = 1'b1;
  logic [W-1:0] data_o, drive_en_o;
  logic         valid_o;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk_i = ~clk_i;

  angle_readout_mux #(.ANGLE_W(W), .SETTLE_CYC(SETTLE)) uut (
    .clk_i, .rst_ni, .ang_a_i, .upd_a_i, .ang_b_i, .upd_b_i,
    .oe_ni, .sel_a_i, .data_o, .drive_en_o, .valid_o
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #5;
    chk("R8 reset drive_en", 32'(drive_en_o), 32'h0);
    chk("R8 reset data", 32'(data_o), 32'h0);
    chk("R8 reset valid", 32'(valid_o), 32'h0);
    rst_ni = 1'b1;

    for (int i = 0; i < 8; i++) begin
      oe_ni   = VECS[i].oe_n;
      sel_a_i = VECS[i].sel;
      ang_a_i = VECS[i].a;
      upd_a_i = VECS[i].ua;
      ang_b_i = VECS[i].b;
      upd_b_i = VECS[i].ub;
      @(posedge clk_i);
      #5;
      chk($sformatf("R2 vec%0d drive_en", i), 32'(drive_en_o),
          VECS[i].exp_on ? 32'h3fff : 32'h0);
      chk($sformatf("R1 R3 R4 R5 vec%0d data", i), 32'(data_o), 32'(VECS[i].exp_data));
    end

    upd_a_i = 1'b0;
    upd_b_i = 1'b0;
    oe_ni   = 1'b1;
    repeat (2) @(posedge clk_i);
    #5;
    chk("R8 valid low while released", 32'(valid_o), 32'h0);

    // R6 settling after enable falls
    oe_ni = 1'b0;
    repeat (SETTLE - 1) @(posedge clk_i);
    #5;
    chk("R6 valid before count ends", 32'(valid_o), 32'h0);
    @(posedge clk_i);
    #5;
    chk("R6 valid after count ends", 32'(valid_o), 32'h1);
    chk("R1 channel A data", 32'(data_o), 32'h0001);

    // R7 select change mid-read
    sel_a_i = 1'b0;
    #1;
    chk("R7 valid drops same cycle", 32'(valid_o), 32'h0);
    chk("R1 channel B data", 32'(data_o), 32'h3fff);
    repeat (SETTLE - 1) @(posedge clk_i);
    #5;
    chk("R7 valid before recount ends", 32'(valid_o), 32'h0);
    @(posedge clk_i);
    #5;
    chk("R7 valid after recount", 32'(valid_o), 32'h1);

    // R3 frozen B ignores strobe, R5 then reloads
    ang_b_i = 14'h2aaa;
    upd_b_i = 1'b1;
    @(posedge clk_i);
    #5;
    upd_b_i = 1'b0;
    chk("R3 frozen B ignores strobe", 32'(data_o), 32'h3fff);
    sel_a_i = 1'b1;
    @(posedge clk_i);
    #5;
    sel_a_i = 1'b0;
    #1;
    chk("R5 B reloaded after read", 32'(data_o), 32'h2aaa);

    finish_run();
  end
endmodule